// File: doc/BRIEF.md
# Register-Mapped GPIO Port with Edge Capture

This block is a general-purpose I/O port of up to 32 pins that sits on a simple word-addressed bus. Each bus cycle carries a write strobe, a read strobe, a two-bit word index and 32 data bits. Software sets an output value register and a per-pin direction register. Together they drive a tri-state style pin pair: `pin_out` carries the value and `pin_oe` enables the driver. The pin inputs pass through a two-flop synchronizer. The synchronized levels can be read back over the bus.

Pin transitions are captured into a sticky per-pin register, and a write of ones clears the matching bits. A per-pin mask gates the capture bits into one combined interrupt line. The trigger kind is chosen when the block is built: rising edge, falling edge, either edge, or level-high. In level-high mode the interrupt follows the masked live pin levels and the capture register stays empty. A chip integrator instantiates one port per pin group and routes `irq` to the interrupt controller.

Top module: `gpio_edge_port`

## Requirements
- R1: The word index on `bus_addr` selects the register: 0 = pin data (byte offset 0x0), 1 = direction (0x4), 2 = interrupt mask (0x8), 3 = edge capture (0xC).
- R2: After a synchronous reset (`rst_n` low at a clock edge), the output value, direction, mask and capture registers are all zero. As a result, `pin_out`, `pin_oe` and `irq` are 0, and every register reads as 0.
- R3: A write to index 0 sets `pin_out` from bits [NUM_PINS-1:0] of `bus_wdata` at that clock edge. A write to index 1 sets `pin_oe` the same way, where 1 means the pin is driven as an output and 0 means it is an input.
- R4: `bus_rdata` is loaded at the edge where `bus_rd` is high and is held unchanged at every other edge. Bits at position NUM_PINS and above always read as 0.
- R5: A read of index 0 returns the pin levels after a two-flop synchronizer. A pin value present before edge k is returned by a read sampled at edge k+2 or later.
- R6: In the edge modes, a pin change present before edge k sets its capture bit at edge k+2. A rising edge (0 to 1) counts in rising mode, a falling edge (1 to 0) counts in falling mode, and either change counts in both-edge mode.
- R7: A capture bit stays set until a write to index 3 carries a 1 in that bit position. Written 0 bits leave their capture bits unchanged.
- R8: When a new edge for a pin arrives in the same cycle as a clear write to that pin's bit, the capture bit stays set.
- R9: In the edge modes, `irq` is high exactly while the bitwise AND of the capture and mask registers is non-zero.
- R10: In level-high mode, `irq` is high exactly while the bitwise AND of the synchronized pin levels and the mask is non-zero. In this mode the capture register is never set and reads as 0.
- R11: The mask register is written and read at index 2, where 1 enables the pin's interrupt. With the mask at zero, `irq` stays low whatever the pins do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Output value per pin |
| pin_oe | output | NUM_PINS | Output enable per pin |
| irq | output | 1 | Combined interrupt |

## Verification
Each result is due at a fixed edge after its stimulus:
- A register write reaches `pin_out` and `pin_oe` at the edge that samples it.
- Read data appears one edge after the read strobe.
- A pin change shows in a data read two edges later.
- A capture bit and the edge-mode `irq` follow three edges after the pin change.
- The level-mode `irq` follows two edges after the pin change.

The bench drives inputs on the falling clock edge. It waits at least one full edge beyond each of these latencies before it samples, except in the same-cycle clear test. That test places the clear write on exactly the edge at which the capture occurs. All four trigger kinds are instantiated side by side and receive the same stimulus, so every start and end pattern of a four-pin port is checked against arithmetic expectations.

// File: rtl/gpio_port_pkg.sv
// Package gpio_port_pkg
// Shared types and constants of the register-mapped GPIO port.
// Assumes a 32-bit data bus and a two-bit word index.
package gpio_port_pkg;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 2;
    localparam int MAX_PINS = 32;

    // Word index of each register (byte offset = index * 4)
    localparam logic [ADDR_W-1:0] IDX_DATA = 2'd0;
    localparam logic [ADDR_W-1:0] IDX_DIR  = 2'd1;
    localparam logic [ADDR_W-1:0] IDX_MASK = 2'd2;
    localparam logic [ADDR_W-1:0] IDX_CAP  = 2'd3;

    // Build-time interrupt trigger kind
    typedef enum logic [1:0] {
        TRIG_RISE  = 2'd0,
        TRIG_FALL  = 2'd1,
        TRIG_BOTH  = 2'd2,
        TRIG_LEVEL = 2'd3
    } trig_e;
endpackage

// File: rtl/gpio_in_sync.sv
// Module gpio_in_sync
// Two-flop synchronizer for asynchronous pin levels, plus one more
// register that holds the synchronized level of the previous cycle
// for edge detection. Assumes pins are quasi-static relative to clk.
module gpio_in_sync #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] lvl_q,
    output logic [NUM_PINS-1:0] lvl_prev_q
);
    logic [NUM_PINS-1:0] meta_q;

    // Synchronizer chain and previous-level register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q     <= '0;
            lvl_q      <= '0;
            lvl_prev_q <= '0;
        end else begin
            meta_q     <= pin_in;
            lvl_q      <= meta_q;
            lvl_prev_q <= lvl_q;
        end
    end
endmodule

// File: rtl/gpio_edge_cap.sv
// Module gpio_edge_cap
// Sticky per-pin edge capture. The trigger kind is fixed by TRIG.
// A new edge wins over a clear of the same bit in the same cycle.
// In level mode the register is absent and reads as zero.
// Assumes lvl / lvl_prev come from gpio_in_sync.
module gpio_edge_cap
    import gpio_port_pkg::*;
#(
    parameter int    NUM_PINS = 8,
    parameter trig_e TRIG     = TRIG_RISE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] lvl,
    input  logic [NUM_PINS-1:0] lvl_prev,
    input  logic                clr_en,
    input  logic [NUM_PINS-1:0] clr_bits,
    output logic [NUM_PINS-1:0] cap_q
);
    generate
        if (TRIG == TRIG_LEVEL) begin : g_level
            // No capture storage in level mode
            logic unused_level_in;
            assign unused_level_in = ^{lvl, lvl_prev, clr_en, clr_bits, clk, rst_n};
            assign cap_q = '0;
        end else begin : g_edge
            logic [NUM_PINS-1:0] evt;
            logic [NUM_PINS-1:0] cap_d;

            if (TRIG == TRIG_RISE) begin : g_rise
                assign evt = lvl & ~lvl_prev;
            end else if (TRIG == TRIG_FALL) begin : g_fall
                assign evt = ~lvl & lvl_prev;
            end else begin : g_both
                assign evt = lvl ^ lvl_prev;
            end

            for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
                // Next state per bit: set by edge, else clear by write-one
                assign cap_d[i] = evt[i] | (cap_q[i] & ~(clr_en & clr_bits[i]));
            end

            // Capture register update
            always_ff @(posedge clk) begin
                if (!rst_n) cap_q <= '0;
                else        cap_q <= cap_d;
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_ctrl_regs.sv
// Module gpio_ctrl_regs
// Software-written registers: output value, direction and interrupt
// mask. Only the low NUM_PINS bits of a write are stored.
module gpio_ctrl_regs
    import gpio_port_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NUM_PINS-1:0] wbits,
    output logic [NUM_PINS-1:0] data_q,
    output logic [NUM_PINS-1:0] dir_q,
    output logic [NUM_PINS-1:0] mask_q
);
    // Register writes decoded by word index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
            mask_q <= '0;
        end else if (wr) begin
            case (addr)
                IDX_DATA: data_q <= wbits;
                IDX_DIR:  dir_q  <= wbits;
                IDX_MASK: mask_q <= wbits;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_read_mux.sv
// Module gpio_read_mux
// Registered read path. The selected register is zero-extended to the
// bus width on a read strobe, and the result is held between reads.
module gpio_read_mux
    import gpio_port_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NUM_PINS-1:0] lvl,
    input  logic [NUM_PINS-1:0] dir,
    input  logic [NUM_PINS-1:0] mask,
    input  logic [NUM_PINS-1:0] cap,
    output logic [BUS_W-1:0]    rdata
);
    logic [NUM_PINS-1:0] sel;

    // Select the addressed register
    always_comb begin
        case (addr)
            IDX_DATA: sel = lvl;
            IDX_DIR:  sel = dir;
            IDX_MASK: sel = mask;
            default:  sel = cap;
        endcase
    end

    // Load read data on strobe, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= BUS_W'(sel);
    end
endmodule

// File: rtl/gpio_edge_port.sv
// Module gpio_edge_port
// Register-mapped GPIO port with output value / direction registers,
// synchronized inputs, sticky edge capture and one masked interrupt.
// Assumes NUM_PINS is between 1 and 32 and TRIG is fixed at build time.
module gpio_edge_port
    import gpio_port_pkg::*;
#(
    parameter int    NUM_PINS = 8,
    parameter trig_e TRIG     = TRIG_RISE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [1:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);
    logic [NUM_PINS-1:0] lvl_q;
    logic [NUM_PINS-1:0] lvl_prev_q;
    logic [NUM_PINS-1:0] data_q;
    logic [NUM_PINS-1:0] dir_q;
    logic [NUM_PINS-1:0] mask_q;
    logic [NUM_PINS-1:0] cap_q;
    logic [NUM_PINS-1:0] wbits;
    logic                clr_en;

    assign wbits  = bus_wdata[NUM_PINS-1:0];
    assign clr_en = bus_wr && (bus_addr == IDX_CAP);

    generate
        if (NUM_PINS < BUS_W) begin : g_upper
            logic unused_wdata_hi;
            assign unused_wdata_hi = ^bus_wdata[BUS_W-1:NUM_PINS];
        end
    endgenerate

    gpio_in_sync #(.NUM_PINS(NUM_PINS)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_in     (pin_in),
        .lvl_q      (lvl_q),
        .lvl_prev_q (lvl_prev_q)
    );

    gpio_ctrl_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .wbits  (wbits),
        .data_q (data_q),
        .dir_q  (dir_q),
        .mask_q (mask_q)
    );

    gpio_edge_cap #(.NUM_PINS(NUM_PINS), .TRIG(TRIG)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (lvl_q),
        .lvl_prev (lvl_prev_q),
        .clr_en   (clr_en),
        .clr_bits (wbits),
        .cap_q    (cap_q)
    );

    gpio_read_mux #(.NUM_PINS(NUM_PINS)) u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (bus_rd),
        .addr  (bus_addr),
        .lvl   (lvl_q),
        .dir   (dir_q),
        .mask  (mask_q),
        .cap   (cap_q),
        .rdata (bus_rdata)
    );

    assign pin_out = data_q;
    assign pin_oe  = dir_q;

    generate
        if (TRIG == TRIG_LEVEL) begin : g_irq_level
            // Level mode: masked live levels
            assign irq = |(lvl_q & mask_q);
        end else begin : g_irq_edge
            // Edge modes: masked sticky captures
            assign irq = |(cap_q & mask_q);
        end
    endgenerate
endmodule

// File: rtl/gpio_edge_port_chk.sv
// Module gpio_edge_port_chk
// Assertion checker bound to gpio_edge_port.
module gpio_edge_port_chk
    import gpio_port_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic [1:0]          bus_addr,
    input logic [31:0]         bus_wdata,
    input logic [31:0]         bus_rdata,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic [NUM_PINS-1:0] mask_q,
    input logic [NUM_PINS-1:0] cap_q,
    input logic                irq
);
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pin_out == '0 && pin_oe == '0 && !irq)); // R2
    AST_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == IDX_DATA) |=> pin_out == $past(bus_wdata[NUM_PINS-1:0])); // R3
    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == IDX_DIR) |=> pin_oe == $past(bus_wdata[NUM_PINS-1:0])); // R3
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R4
    AST_CAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == IDX_CAP) |=> (($past(cap_q) & ~cap_q) == '0)); // R7
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq); // R11
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .mask_q    (mask_q),
    .cap_q     (cap_q),
    .irq       (irq)
);

// File: tb/tb_gpio_edge_port.sv
// Bench for gpio_edge_port: four instances, one per trigger kind, share
// the same bus and pins; expectations are computed arithmetically.
module tb_gpio_edge_port;
    import gpio_port_pkg::*;
    localparam int NP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [NP-1:0] pin_in = '0;

    logic [31:0] rd_r, rd_f, rd_b, rd_l;
    logic [NP-1:0] po_r, po_f, po_b, po_l, oe_r, oe_f, oe_b, oe_l;
    logic irq_r, irq_f, irq_b, irq_l;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_edge_port #(.NUM_PINS(NP), .TRIG(TRIG_RISE)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_r), .pin_in(pin_in), .pin_out(po_r),
        .pin_oe(oe_r), .irq(irq_r));
    gpio_edge_port #(.NUM_PINS(NP), .TRIG(TRIG_FALL)) dut_fall (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_f), .pin_in(pin_in), .pin_out(po_f),
        .pin_oe(oe_f), .irq(irq_f));
    gpio_edge_port #(.NUM_PINS(NP), .TRIG(TRIG_BOTH)) dut_both (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_b), .pin_in(pin_in), .pin_out(po_b),
        .pin_oe(oe_b), .irq(irq_b));
    gpio_edge_port #(.NUM_PINS(NP), .TRIG(TRIG_LEVEL)) dut_lvl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_l), .pin_in(pin_in), .pin_out(po_l),
        .pin_oe(oe_l), .irq(irq_l));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bwrite(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bread(input logic [1:0] a);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_pins(input logic [NP-1:0] v);
        @(negedge clk);
        pin_in = v;
        idle(4);
    endtask

    // Watchdog
    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        chk("R2 pin_oe", 32'(oe_r), 0);
        chk("R2 pin_out", 32'(po_r), 0);
        chk("R2 irq", 32'({irq_r, irq_f, irq_b, irq_l}), 0);
        for (int a = 0; a < 4; a++) begin
            bread(2'(a));
            chk("R2 read zero", rd_r | rd_l, 0);
        end

        // R3/R1/R4: output value and direction sweep
        for (int v = 0; v < 16; v++) begin
            bwrite(IDX_DATA, 32'hFFFF_FFF0 | v);
            chk("R3 pin_out", 32'(po_r), v);
            bwrite(IDX_DIR, 32'hABCD_0000 | (v ^ 5));
            chk("R3 pin_oe", 32'(oe_b), v ^ 5);
            bread(IDX_DIR);
            chk("R1 R4 dir readback", rd_r, v ^ 5);
        end

        // R11: mask readback with upper bits dropped
        bwrite(IDX_MASK, 32'h8000_0009);
        bread(IDX_MASK);
        chk("R11 mask readback", rd_f, 9);

        // R5: synchronized pin levels on data index
        for (int v = 0; v < 16; v++) begin
            set_pins(4'(v));
            bread(IDX_DATA);
            chk("R5 data read", rd_l, v);
        end

        // R4: read data holds without a read strobe
        bread(IDX_MASK);
        set_pins(4'hA);
        bwrite(IDX_MASK, 32'h3);
        idle(3);
        chk("R4 rdata hold", rd_r, 9);

        // R6/R9/R10: all start/end pin patterns, mask fully open
        bwrite(IDX_MASK, 32'hF);
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                set_pins(4'(a));
                bwrite(IDX_CAP, 32'hF);
                set_pins(4'(b));
                bread(IDX_CAP);
                chk("R6 rise capture", rd_r, b & ~a);
                chk("R6 fall capture", rd_f, a & ~b);
                chk("R6 both capture", rd_b, a ^ b);
                chk("R10 level capture zero", rd_l, 0);
                chk("R9 irq rise", 32'(irq_r), ((b & ~a) != 0) ? 1 : 0);
                chk("R9 irq both", 32'(irq_b), ((a ^ b) != 0) ? 1 : 0);
                chk("R10 irq level", 32'(irq_l), (b != 0) ? 1 : 0);
            end
        end

        // R9/R10/R11: mask sweep with all captures set and all pins high
        set_pins(4'h0);
        bwrite(IDX_CAP, 32'hF);
        set_pins(4'hF);
        for (int m = 0; m < 16; m++) begin
            bwrite(IDX_MASK, 32'(m));
            chk("R9 R11 irq rise vs mask", 32'(irq_r), (m != 0) ? 1 : 0);
            chk("R10 R11 irq level vs mask", 32'(irq_l), (m != 0) ? 1 : 0);
            chk("R11 irq fall no capture", 32'(irq_f), 0);
        end

        // R7: partial clear leaves written-zero bits set
        bwrite(IDX_CAP, 32'h5);
        bread(IDX_CAP);
        chk("R7 partial clear", rd_b, 4'hA);
        idle(5);
        bread(IDX_CAP);
        chk("R7 sticky", rd_b, 4'hA);

        // R8: clear write on the same edge as a new rising capture
        set_pins(4'h0);
        bwrite(IDX_CAP, 32'hF);
        set_pins(4'h1);
        set_pins(4'h0);
        @(negedge clk);
        pin_in = 4'h1;
        idle(2);
        bus_wr = 1'b1; bus_addr = IDX_CAP; bus_wdata = 32'h1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        bread(IDX_CAP);
        chk("R8 edge beats clear", rd_r, 1);
        bwrite(IDX_CAP, 32'h1);
        bread(IDX_CAP);
        chk("R7 R8 later clear", rd_r, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule